// File: doc/BRIEF.md
# Iterative Restoring Division Step Unit

This block is an unsigned divider datapath that advances only when commanded. An init command loads a dividend and a divisor. It clears the quotient, places the dividend in the partial remainder and makes one aligned subtraction. Each later step command supplies a source word and a count of the low dividend bits still to be pulled in. The unit moves those bits, one at a time, into the partial remainder and doubles the quotient for each bit moved. It then makes one aligned subtraction and returns the new count together with an optional zero flag.

An aligned subtraction lines up the leading one of the divisor with the leading one of the partial remainder. If the shifted divisor is then too large, it backs off by one bit. A single subtraction can therefore retire more than one quotient bit. The caller repeats step commands, feeding back the returned count, until the count reaches zero. The quotient and remainder registers are visible on output ports at all times, and every command completes in one clock with a registered done pulse.

Top module: `divstep_unit`

## Requirements
- R1: After reset, quotient, remainder, count_out, zero_flag, done and div_zero are all zero.
- R2: An init command whose divisor is zero raises div_zero together with done and leaves quotient and remainder unchanged.
- R3: An init command whose divisor is larger than its dividend ends with quotient 0 and remainder equal to the dividend.
- R4: An aligned subtraction uses weight 2^k, where k is the leading-one position of the partial remainder minus that of the divisor. The weight and the shifted divisor are both halved when the shifted divisor exceeds the partial remainder. The weight is added to the quotient and the shifted divisor is subtracted from the remainder; for example, 100 divided by 7 gives quotient 8 and remainder 44.
- R5: A step command with count_in 0 leaves quotient and remainder unchanged and returns count_out 0.
- R6: A step command with count_in c>0 shifts bits c-1, c-2, ... of word_a into the partial remainder from its low end, doubling the quotient for each bit. It stops as soon as the partial remainder is not below the divisor or the count is exhausted, then makes one aligned subtraction, and count_out gives the bits still unused.
- R7: On a step command with zf_en high, zero_flag becomes 1 if the new count is zero and 0 otherwise. With zf_en low, zero_flag keeps its value.
- R8: done is high for exactly the one cycle that follows each accepted command.
- R9: After an init with dividend H and divisor D (H<D), step commands with word_a L repeated until count_out is 0 leave quotient and remainder equal to the 128-bit quotient and remainder of {H,L} divided by D. The first of these steps uses count 64, and each later step passes back the previous count_out.
- R10: A step command with nonzero count_in while the stored divisor is zero (e.g. before any init) raises div_zero and leaves quotient, remainder and count_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_step | input | 1 | 0 = init, 1 = step |
| word_a | input | W | Dividend (init) or source word (step) |
| divisor_in | input | W | Divisor (init only) |
| count_in | input | CW | Bits still to bring in (step only), at most W |
| zf_en | input | 1 | Enables update of zero_flag on a step |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divide-by-zero error, valid with done |
| count_out | output | CW | Updated remaining count |
| zero_flag | output | 1 | Count-reached-zero flag |
| quotient | output | W | Quotient register |
| remainder | output | W | Partial remainder register |

## Verification
The assertions take it for granted that count_in never exceeds the word width. They also assume a step only ever follows from states the unit itself produced, so the bound on the returned count depends on count_in being in range. The stimulus draws every step count from 0 to 64. Full sequences use a high dividend word below the divisor, so the final quotient fits in one word. The random mix keeps zero divisors rare, and they are covered by directed cases.

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_step,
  input  logic [W-1:0]             word_a,
  input  logic [W-1:0]             divisor_in,
  input  logic [$clog2(W+1)-1:0]   count_in,
  input  logic                     zf_en,
  output logic                     done,
  output logic                     div_zero,
  output logic [$clog2(W+1)-1:0]   count_out,
  output logic                     zero_flag,
  output logic [W-1:0]             quotient,
  output logic [W-1:0]             remainder
);
  localparam int CW = $clog2(W+1);
  localparam int XW = W + 1;

  logic [W-1:0]  quo_r, rem_r, div_r;
  logic [CW-1:0] cnt_r;
  logic          zf_r, done_r, dz_r;

  logic [W-1:0]  n_quo;
  logic [XW-1:0] n_pd;
  logic [CW-1:0] n_cnt;
  logic          n_dz;

  function automatic int unsigned lead1(input logic [XW-1:0] v);
    int unsigned p;
    p = 0;
    for (int i = 0; i < XW; i++)
      if (v[i]) p = i;
    return p;
  endfunction

  always_comb begin
    logic [XW-1:0] pd, dv, ad, wt;
    logic [W-1:0]  q;
    logic [CW-1:0] rc;
    logic          go;
    int unsigned   sh;
    ad = '0;
    wt = '0;
    sh = 0;
    if (!cmd_step) begin
      dv = {1'b0, divisor_in};
      pd = {1'b0, word_a};
      q  = '0;
      rc = cnt_r;
      go = 1'b1;
    end else begin
      dv = {1'b0, div_r};
      pd = {1'b0, rem_r};
      q  = quo_r;
      rc = count_in;
      go = (count_in != '0);
      for (int i = 0; i < W; i++) begin
        if (go && (pd < dv) && (rc != '0)) begin
          pd = {pd[W-1:0], word_a[rc - 1'b1]};
          q  = {q[W-2:0], 1'b0};
          rc = rc - 1'b1;
        end
      end
    end
    if (go && (dv != '0) && (dv <= pd)) begin
      sh = lead1(pd) - lead1(dv);
      ad = dv << sh;
      wt = XW'(1) << sh;
      if (ad > pd) begin
        ad = ad >> 1;
        wt = wt >> 1;
      end
      q  = q + wt[W-1:0];
      pd = pd - ad;
    end
    n_quo = q;
    n_pd  = pd;
    n_cnt = rc;
    n_dz  = go && (dv == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_r  <= '0;
      rem_r  <= '0;
      div_r  <= '0;
      cnt_r  <= '0;
      zf_r   <= 1'b0;
      done_r <= 1'b0;
      dz_r   <= 1'b0;
    end else begin
      done_r <= cmd_valid;
      dz_r   <= cmd_valid && n_dz;
      if (cmd_valid && !n_dz) begin
        quo_r <= n_quo;
        rem_r <= n_pd[W-1:0];
        if (!cmd_step) begin
          div_r <= divisor_in;
        end else begin
          cnt_r <= n_cnt;
          if (zf_en) zf_r <= (n_cnt == '0);
        end
      end
    end
  end

  assign done      = done_r;
  assign div_zero  = dz_r;
  assign count_out = cnt_r;
  assign zero_flag = zf_r;
  assign quotient  = quo_r;
  assign remainder = rem_r;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  // R2
  dz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (quotient == $past(quotient)) && (remainder == $past(remainder)));
  // R5
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_step && count_in == '0) |=> (count_out == '0) && $stable(quotient) && $stable(remainder));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_step && count_in != '0) |=> (count_out <= $past(count_in)));
  // R10
  dz_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (count_out == $past(count_out)));
endmodule

// File: tb/divstep_unit_test.sv
module divstep_unit_test;
  localparam int W  = 64;
  localparam int CW = $clog2(W+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_step = 1'b0, zf_en = 1'b0;
  logic [W-1:0] word_a = '0, divisor_in = '0;
  logic [CW-1:0] count_in = '0;
  logic done, div_zero, zero_flag;
  logic [CW-1:0] count_out;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0, n_bad = 0, cycles = 0;

  logic [W-1:0] m_quo = '0, m_rem = '0, m_div = '0;
  logic [CW-1:0] m_cnt = '0;
  logic m_zf = 1'b0, m_dz = 1'b0;

  divstep_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_step(cmd_step),
    .word_a(word_a), .divisor_in(divisor_in), .count_in(count_in), .zf_en(zf_en),
    .done(done), .div_zero(div_zero), .count_out(count_out), .zero_flag(zero_flag),
    .quotient(quotient), .remainder(remainder)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int msb_of(input logic [W:0] v);
    int p = -1;
    for (int i = W; i >= 0; i--)
      if (p < 0 && v[i]) p = i;
    return p;
  endfunction

  task automatic ref_sub(inout logic [W:0] r, inout logic [W-1:0] q, input logic [W-1:0] d);
    logic [W:0] dd, b;
    int k;
    if (d != 0 && {1'b0, d} <= r) begin
      k  = msb_of(r) - msb_of({1'b0, d});
      dd = {1'b0, d} << k;
      b  = (W+1)'(1) << k;
      if (dd > r) begin dd = dd >> 1; b = b >> 1; end
      q = q + b[W-1:0];
      r = r - dd;
    end
  endtask

  task automatic ref_init(input logic [W-1:0] a, input logic [W-1:0] d);
    logic [W:0] r;
    logic [W-1:0] q;
    m_dz = (d == 0);
    if (!m_dz) begin
      r = {1'b0, a};
      q = '0;
      ref_sub(r, q, d);
      m_quo = q; m_rem = r[W-1:0]; m_div = d;
    end
  endtask

  task automatic ref_step(input logic [W-1:0] src, input logic [CW-1:0] c, input logic ze);
    logic [W:0] r;
    logic [W-1:0] q;
    int cc;
    m_dz = (c != 0) && (m_div == 0);
    if (m_dz) return;
    cc = int'(c);
    r = {1'b0, m_rem};
    q = m_quo;
    if (cc != 0) begin
      while (r < {1'b0, m_div} && cc > 0) begin
        r = {r[W-1:0], src[cc-1]};
        q = q << 1;
        cc--;
      end
      ref_sub(r, q, m_div);
    end
    m_quo = q; m_rem = r[W-1:0]; m_cnt = CW'(cc);
    if (ze) m_zf = (cc == 0);
  endtask

  task automatic issue(input logic stp, input logic [W-1:0] a, input logic [W-1:0] d,
                       input logic [CW-1:0] c, input logic ze);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_step = stp; word_a = a; divisor_in = d; count_in = c; zf_en = ze;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cmp_all(input string tag);
    chk({"R8 done ", tag}, W'(done), W'(1));
    chk({"R2 div_zero ", tag}, W'(div_zero), W'(m_dz));
    chk({tag, " quotient"}, quotient, m_quo);
    chk({tag, " remainder"}, remainder, m_rem);
    chk({tag, " count"}, W'(count_out), W'(m_cnt));
    chk({"R7 zero_flag ", tag}, W'(zero_flag), W'(m_zf));
  endtask

  task automatic do_init(input logic [W-1:0] a, input logic [W-1:0] d, input string tag);
    ref_init(a, d);
    issue(1'b0, a, d, '0, 1'b0);
    cmp_all(tag);
  endtask

  task automatic do_step(input logic [W-1:0] s, input logic [CW-1:0] c, input logic ze, input string tag);
    ref_step(s, c, ze);
    issue(1'b1, s, '0, c, ze);
    cmp_all(tag);
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 quotient", quotient, '0);
    chk("R1 remainder", remainder, '0);
    chk("R1 count", W'(count_out), '0);
    chk("R1 flags", W'({done, div_zero, zero_flag}), '0);

    // R10 step before any init
    do_step(64'hFFFF, 7'd5, 1'b1, "R10");
    chk("R10 div_zero raised", W'(div_zero), W'(1));
    // R8 done drops after one cycle
    @(negedge clk);
    chk("R8 done low when idle", W'(done), W'(0));

    // R4 100/7 -> quotient 8 remainder 44
    do_init(64'd100, 64'd7, "R4");
    chk("R4 quotient 100/7", quotient, 64'd8);
    chk("R4 remainder 100/7", remainder, 64'd44);
    // R4 exact alignment without back-off: 96/3 -> 32, 0
    do_init(64'd96, 64'd3, "R4");
    chk("R4 quotient 96/3", quotient, 64'd32);
    chk("R4 remainder 96/3", remainder, 64'd0);

    // R2 zero divisor leaves state
    do_init(64'd1234, 64'd0, "R2");
    chk("R2 div_zero raised", W'(div_zero), W'(1));
    chk("R2 quotient kept", quotient, 64'd32);

    // R3 divisor above dividend
    do_init(64'd5, 64'd9, "R3");
    chk("R3 quotient", quotient, 64'd0);
    chk("R3 remainder", remainder, 64'd5);

    // R6 step pulls bits 3..: rem 5, div 9, src bits 0b1010 from index 3
    // 5 -> 11 (bit3=1) >= 9 stop, q=0, sub -> q=1 rem=2, count 3
    do_step(64'hA, 7'd4, 1'b1, "R6");
    chk("R6 quotient", quotient, 64'd1);
    chk("R6 remainder", remainder, 64'd2);
    chk("R6 count", W'(count_out), W'(3));
    chk("R7 nonzero count clears flag", W'(zero_flag), W'(0));

    // R5 zero count does nothing
    do_step(64'hFFFF_FFFF, 7'd0, 1'b0, "R5");
    chk("R5 quotient kept", quotient, 64'd1);
    chk("R5 count zero", W'(count_out), W'(0));
    chk("R7 flag held when disabled", W'(zero_flag), W'(0));
    do_step(64'h0, 7'd0, 1'b1, "R7");
    chk("R7 flag set on zero count", W'(zero_flag), W'(1));

    // R9 full sequences
    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] d, hi, lo;
      logic [2*W-1:0] full;
      int guard;
      d = rnd64();
      if (t % 4 == 0) d = d >> ($urandom() % 60);
      if (d == 0) d = 64'd3;
      hi = rnd64() % d;
      lo = rnd64();
      full = {hi, lo};
      do_init(hi, d, "R9");
      do_step(lo, 7'd64, 1'b1, "R9");
      guard = 0;
      while (count_out != 0 && guard < 70) begin
        do_step(lo, count_out, 1'b1, "R9");
        guard++;
      end
      chk("R9 final quotient", quotient, W'(full / {64'd0, d}));
      chk("R9 final remainder", remainder, W'(full % {64'd0, d}));
      chk("R7 flag at end", W'(zero_flag), W'(1));
    end

    // R6 random mix against the reference
    for (int t = 0; t < 300; t++) begin
      if ($urandom() % 4 == 0) begin
        logic [W-1:0] d;
        d = rnd64() >> ($urandom() % 64);
        if ($urandom() % 20 == 0) d = '0;
        do_init(rnd64() >> ($urandom() % 64), d, "R3");
      end else begin
        do_step(rnd64(), CW'($urandom() % 65), 1'($urandom()), "R6");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule